// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block takes the two lines of a low-speed USB pair (D+ and D-), brings them into the core clock domain and locks to the 1.5 Mb/s bit stream. A fractional phase accumulator handles bit periods that are not a whole number of core clocks. The accumulator is pulled back to the bit edge on every line transition, so each sample lands at mid-bit.

A packet starts with the sync field. The receiver locks onto a J-to-K transition and confirms the end of sync when it sees two K bits in a row. It then undoes the NRZI coding, drops the bit stuffed after six ones and assembles bytes least-significant bit first. Each finished byte is offered on a one-cycle write port with its buffer index. An external buffer of `DEPTH` entries takes the bytes.

An SE0 sample closes the packet with a done pulse and the byte count. A packet longer than the buffer is aborted with an overflow pulse and never reported as done.

Top module: `lsusb_rx`

## Requirements
- R1: Line states are coded as {D+, D-}: J = 01 (idle), K = 10, SE0 = 00. Reception starts only after a J sample followed by a K sample, and then a second K at the next bit sample. If a J comes where the second K was due, the receiver hunts again and produces no output.
- R2: NRZI decoding: a sampled line state equal to the previous reference state gives a 1, and a different state gives a 0. Every decoded bit makes its sample the new reference.
- R3: The ones run starts at 1 after sync, because the final sync K decodes as a 1. It grows with each decoded 1 and clears on each 0. When it reaches 6, the next bit sample is a stuff bit: it is discarded, becomes the reference and clears the run.
- R4: Data bits fill bytes least-significant bit first. Each finished byte is presented on `byte_o` with a one-cycle `byte_vld_o`. `byte_idx_o` counts 0, 1, 2 and so on within a packet.
- R5: An SE0 sample during reception gives a one-cycle `done_o`, with `done_cnt_o` set to the number of complete bytes. Bits of an unfinished byte are dropped.
- R6: A byte that finishes when `DEPTH` bytes are already stored is not written. Instead `ovf_o` pulses for one cycle, and the rest of the packet up to its SE0 is ignored with no `done_o`.
- R7: After a done or an abort, a fresh J sample and then a J-to-K edge are needed before a new packet. SE0 while hunting has no effect, and the next packet is received normally.
- R8: Bit timing comes from a phase accumulator that adds round(BIT_HZ * 2^ACC_W / CLK_HZ) per clock and is reset to half scale on every line transition. Packets sent 1% fast or 1% slow are received correctly.
- R9: While reset is high and after it is released, `byte_vld_o`, `done_o` and `ovf_o` are low and `byte_o` and `done_cnt_o` are zero.
- R10: A sync field followed directly by SE0 gives `done_o` with `done_cnt_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, oversampling the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| byte_o | output | 8 | Received data byte |
| byte_vld_o | output | 1 | One-cycle write strobe for `byte_o` |
| byte_idx_o | output | $clog2(DEPTH) | Buffer index for the byte being written |
| done_o | output | 1 | One-cycle end-of-packet pulse |
| done_cnt_o | output | $clog2(DEPTH+1) | Bytes received in the finished packet |
| ovf_o | output | 1 | One-cycle overflow/abort pulse |

## Verification
Completion of a byte and completion of a six-ones run can land on the same bit sample. The stuff bit then falls right after the byte boundary instead of inside a byte. Data such as 0xFC, whose last six bits are ones, and 0xFF runs provoke this case, so the stuff bit has to be dropped while the byte index moves on. The byte that overflows the buffer and the abort also share one sample, and there the bench expects `ovf_o` and no write. A behavioural model holds the expected bytes in a queue and checks every clock that each strobe, index, count and pulse matches.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;
  // {D+, D-}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_SYNC2,
    ST_RECV,
    ST_DROP
  } rx_st_t;
endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= rst_val_i;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lsrx_dpll.sv
module lsrx_dpll
  import lsrx_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int INC   = 983
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t line_i,
  output logic  stb_o,
  output line_t smp_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  line_t          prev_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             trans;

  assign sum   = {1'b0, acc_q} + (ACC_W+1)'(INC);
  assign trans = (line_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= LS_J;
      acc_q  <= '0;
      stb_o  <= 1'b0;
      smp_o  <= LS_J;
    end else begin
      prev_q <= line_i;
      stb_o  <= 1'b0;
      if (trans) begin
        acc_q <= HALF;
      end else begin
        acc_q <= sum[ACC_W-1:0];
        if (sum[ACC_W]) begin
          stb_o <= 1'b1;
          smp_o <= line_i;
        end
      end
    end
  end

  // R8
  recentre_chk: assert property (@(posedge clk) disable iff (rst)
    trans |-> ##2 !stb_o);
endmodule

// File: rtl/lsrx_recv.sv
module lsrx_recv
  import lsrx_pkg::*;
#(
  parameter int DEPTH = 11,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  line_t            smp_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             done_o,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic             ovf_o
);
  rx_st_t           st_q;
  logic             armed_q;
  line_t            ref_q;
  logic [2:0]       ones_q;
  logic [2:0]       bit_q;
  logic [7:0]       shf_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dbit;
  logic [7:0]       nxt_byte;

  assign dbit     = (smp_i == ref_q);
  assign nxt_byte = {dbit, shf_q[7:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HUNT;
      armed_q    <= 1'b0;
      ref_q      <= LS_J;
      ones_q     <= '0;
      bit_q      <= '0;
      shf_q      <= '0;
      cnt_q      <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      byte_idx_o <= '0;
      done_o     <= 1'b0;
      done_cnt_o <= '0;
      ovf_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      done_o     <= 1'b0;
      ovf_o      <= 1'b0;
      if (stb_i) begin
        unique case (st_q)
          ST_HUNT: begin
            if (smp_i == LS_J) armed_q <= 1'b1;
            else if (smp_i == LS_K && armed_q) st_q <= ST_SYNC2;
          end
          ST_SYNC2: begin
            if (smp_i == LS_K) begin
              st_q   <= ST_RECV;
              ref_q  <= LS_K;
              ones_q <= 3'd1;
              bit_q  <= '0;
              cnt_q  <= '0;
            end else begin
              st_q    <= ST_HUNT;
              armed_q <= (smp_i == LS_J);
            end
          end
          ST_RECV: begin
            if (smp_i == LS_SE0) begin
              done_o     <= 1'b1;
              done_cnt_o <= cnt_q;
              st_q       <= ST_HUNT;
              armed_q    <= 1'b0;
            end else if (ones_q == 3'd6) begin
              ref_q  <= smp_i;
              ones_q <= '0;
            end else begin
              ref_q  <= smp_i;
              ones_q <= dbit ? ones_q + 3'd1 : 3'd0;
              shf_q  <= nxt_byte;
              bit_q  <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                if (cnt_q == CNT_W'(DEPTH)) begin
                  ovf_o <= 1'b1;
                  st_q  <= ST_DROP;
                end else begin
                  byte_vld_o <= 1'b1;
                  byte_o     <= nxt_byte;
                  byte_idx_o <= cnt_q[IDX_W-1:0];
                  cnt_q      <= cnt_q + CNT_W'(1);
                end
              end
            end
          end
          ST_DROP: begin
            if (smp_i == LS_SE0) begin
              st_q    <= ST_HUNT;
              armed_q <= 1'b0;
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  // R3
  ones_run_chk: assert property (@(posedge clk) disable iff (rst)
    ones_q <= 3'd6);
  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> (byte_idx_o < IDX_W'(DEPTH)));
  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!byte_vld_o && done_cnt_o <= CNT_W'(DEPTH)));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_q == CNT_W'(DEPTH) && !byte_vld_o && !done_o));
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
  import lsrx_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter longint unsigned BIT_HZ = 1_500_000,
  parameter int ACC_W = 16,
  parameter int DEPTH = 11,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam longint unsigned INC_L =
    (BIT_HZ * (64'd1 << ACC_W) + CLK_HZ / 2) / CLK_HZ
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp_i,
  input  logic             dm_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             done_o,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic             ovf_o
);
  logic [1:0] line_s;
  logic       stb;
  line_t      smp;

  lsrx_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i({dp_i, dm_i}), .rst_val_i(LS_J), .q_o(line_s)
  );

  lsrx_dpll #(.ACC_W(ACC_W), .INC(int'(INC_L))) u_dpll (
    .clk(clk), .rst(rst), .line_i(line_t'(line_s)), .stb_o(stb), .smp_o(smp)
  );

  lsrx_recv #(.DEPTH(DEPTH)) u_recv (
    .clk(clk), .rst(rst), .stb_i(stb), .smp_i(smp),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .byte_idx_o(byte_idx_o),
    .done_o(done_o), .done_cnt_o(done_cnt_o), .ovf_o(ovf_o)
  );
endmodule

// File: tb/lsusb_rx_bench.sv
`timescale 1ns/1ps
module lsusb_rx_bench;
  localparam int DEPTH = 11;
  localparam real NOM = 666.667;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp = 1'b0, dm = 1'b1;
  logic [7:0] byte_o;
  logic       byte_vld_o;
  logic [3:0] byte_idx_o;
  logic       done_o;
  logic [3:0] done_cnt_o;
  logic       ovf_o;

  always #5 clk = ~clk;

  lsusb_rx #(.DEPTH(DEPTH)) u_lsusb_rx (
    .clk(clk), .rst(rst), .dp_i(dp), .dm_i(dm),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .byte_idx_o(byte_idx_o),
    .done_o(done_o), .done_cnt_o(done_cnt_o), .ovf_o(ovf_o)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] pkt[$];
  int exp_n, exp_cnt, seen_b, seen_d, seen_o;
  bit exp_done, exp_ovf;
  string tag;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference model, compared every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld_o) begin
        chk(seen_b < exp_n, {tag, " R4 unexpected byte count"}, seen_b + 1, exp_n);
        if (seen_b < exp_n) begin
          chk(byte_o == pkt[seen_b], {tag, " R2 R4 byte value"}, byte_o, pkt[seen_b]);
          chk(int'(byte_idx_o) == seen_b, {tag, " R4 byte index"}, byte_idx_o, seen_b);
        end
        seen_b++;
      end
      if (done_o) begin
        chk(exp_done, {tag, " R5 unexpected done"}, 1, 0);
        chk(int'(done_cnt_o) == exp_cnt, {tag, " R5 done count"}, done_cnt_o, exp_cnt);
        seen_d++;
      end
      if (ovf_o) begin
        chk(exp_ovf, {tag, " R6 unexpected overflow"}, 1, 0);
        seen_o++;
      end
    end
  end

  task automatic put(input logic [1:0] s, input real bn);
    {dp, dm} = s;
    #(bn);
  endtask

  task automatic expect_pkt(input string t);
    tag = t;
    exp_ovf = (pkt.size() > DEPTH);
    exp_n = exp_ovf ? DEPTH : pkt.size();
    exp_done = !exp_ovf;
    exp_cnt = exp_n;
    seen_b = 0; seen_d = 0; seen_o = 0;
  endtask

  task automatic send(input real bn);
    logic [1:0] cur;
    int ones;
    cur = 2'b01;
    put(cur, bn); put(cur, bn);
    for (int i = 0; i < 8; i++) begin
      cur = (i == 7 || i % 2 == 0) ? 2'b10 : 2'b01;
      put(cur, bn);
    end
    ones = 1;
    foreach (pkt[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (pkt[k][i]) ones++;
        else begin cur = ~cur; ones = 0; end
        put(cur, bn);
        if (ones == 6) begin cur = ~cur; put(cur, bn); ones = 0; end
      end
    end
    put(2'b00, bn); put(2'b00, bn);
    for (int i = 0; i < 5; i++) put(2'b01, bn);
  endtask

  task automatic finish_pkt();
    #(200);
    chk(seen_b == exp_n, {tag, " R4 bytes written"}, seen_b, exp_n);
    chk(seen_d == int'(exp_done), {tag, " R5 done pulses"}, seen_d, exp_done);
    chk(seen_o == int'(exp_ovf), {tag, " R6 overflow pulses"}, seen_o, exp_ovf);
  endtask

  initial begin
    tag = "init";
    exp_n = 0; exp_cnt = 0; exp_done = 0; exp_ovf = 0;
    seen_b = 0; seen_d = 0; seen_o = 0;
    #(3.3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R9: outputs during reset
    chk(!byte_vld_o && !done_o && !ovf_o, "R9 pulses in reset", {byte_vld_o, done_o, ovf_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(byte_o == 8'd0 && done_cnt_o == 4'd0, "R9 data after reset", byte_o, 0);
    chk(!byte_vld_o && !done_o && !ovf_o, "R9 pulses after reset", {byte_vld_o, done_o, ovf_o}, 0);

    // R1 R7: SE0 while hunting and a lone K give nothing
    pkt = {}; expect_pkt("idle");
    exp_done = 0;
    put(2'b00, NOM); put(2'b00, NOM);
    for (int i = 0; i < 3; i++) put(2'b01, NOM);
    put(2'b10, NOM);
    for (int i = 0; i < 3; i++) put(2'b01, NOM);
    finish_pkt();

    // R1 R2 R4 R5: plain packet
    pkt = {8'hA5, 8'h3C, 8'h0F}; expect_pkt("basic");
    send(NOM); finish_pkt();

    // R3: stuffing inside and at byte boundaries
    pkt = {8'hFF, 8'h3F, 8'hFE, 8'h7E, 8'hFC, 8'h01}; expect_pkt("stuff");
    send(NOM); finish_pkt();

    // R10: empty packet
    pkt = {}; expect_pkt("empty");
    send(NOM); finish_pkt();

    // R5: buffer exactly full
    pkt = {};
    for (int i = 0; i < DEPTH; i++) pkt.push_back(8'(i * 37 + 5));
    expect_pkt("full");
    send(NOM); finish_pkt();

    // R6: one byte too many
    pkt = {};
    for (int i = 0; i <= DEPTH; i++) pkt.push_back(8'(i * 91 + 200));
    expect_pkt("overflow");
    send(NOM); finish_pkt();

    // R7: receiver recovers after abort
    pkt = {8'h12, 8'h34}; expect_pkt("after_abort");
    send(NOM); finish_pkt();

    // R8: rate offsets
    pkt = {8'hFF, 8'h00, 8'hC3, 8'hFF, 8'h55}; expect_pkt("fast");
    send(NOM * 0.99); finish_pkt();
    pkt = {8'h81, 8'hFF, 8'h7F, 8'hAA}; expect_pkt("slow");
    send(NOM * 1.01); finish_pkt();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(1_900_000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule